// File: doc/BRIEF.md
# Third-Order Cascaded Fractional Modulus Controller

This block steers a multimodulus prescaler so that its average division ratio carries a fraction. It runs on the divider's own output clock. On every enabled cycle it adds a 16-bit fractional word into the first of three chained accumulators. Each later accumulator sums the fresh residue of the one before it. The overflow bits of the three stages are recombined through short delay lines into a signed offset. The offset's spectrum has third-order high-pass shaping, and its long-run mean equals the fractional word over 2^16.

The offset spans −3 to +4 around a nominal ratio. It is presented in two forms: a signed number, and eight one-hot select lines. Each select line picks one prescaler ratio, from N−3 up to N+4, with N nominally 70. Both outputs are registered, so the prescaler sees a clean value for the whole next divider period. Lowering the enable freezes every accumulator, every delay stage and both outputs.

Top module: `mash3_modctl`

## Requirements
- R1: A synchronous active-high `rst` clears the three accumulators and the carry delay registers. After the edge, `offset` reads 0 and `ratio_sel` reads 8'b0000_1000.
- R2: On each enabled edge, stage one adds `frac_word` to its accumulator modulo 2^16. Its carry is the bit that overflows out of bit 15.
- R3: On the same edge, stages two and three each add the newly computed residue of the stage before them to their own accumulator, modulo 2^16. Each produces its own overflow carry.
- R4: The value loaded into `offset` is c1 + (c2 − c2 of the previous enabled edge) + (c3 − 2·c3 one enabled edge back + c3 two enabled edges back). It appears at the edge where the carries are formed.
- R5: `offset` is a 4-bit two's-complement value that always lies between −3 and +4 inclusive.
- R6: `ratio_sel` has exactly one line high. That line is bit index `offset`+3: bit 0 selects N−3 and bit 7 selects N+4.
- R7: While `en` is low, `frac_word` has no effect: accumulators, delay registers, `offset` and `ratio_sel` all hold.
- R8: A `frac_word` of 0 held from reset gives an offset of 0 on every cycle.
- R9: Over 65536 consecutive enabled cycles from reset, the offsets sum to within 2 of `frac_word`. This puts the mean within 1/1000 of `frac_word`/2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divider output clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance accumulators and outputs on this edge |
| frac_word | input | 16 | Unsigned fractional control word |
| offset | output | 4 | Signed modulus offset, −3 to +4 |
| ratio_sel | output | 8 | One-hot prescaler ratio select, bit 0 = N−3 |

## Verification
The bound checker watches, on every clock, four properties:
- the offset stays inside its range;
- the select bus is one-hot;
- the select bus agrees with the offset;
- both outputs freeze while the enable is low, and reset returns them to the zero-offset state.

The exact carry arithmetic, the delay-line recombination and the long-run mean depend on accumulator history. Only the bench's behavioural model shows these, across several fractional words, a paused stretch, a mid-run reset and a full 65536-cycle period.

// File: rtl/mash3_pkg.sv
`timescale 1ns/1ps
package mash3_pkg;
    localparam int ACC_W_DEF   = 16;
    localparam int OFS_W       = 4;
    localparam int OFS_MIN     = -3;
    localparam int OFS_MAX     = 4;
    localparam int SEL_W       = OFS_MAX - OFS_MIN + 1;
    localparam int NUM_STAGES  = 3;

    typedef logic signed [OFS_W-1:0] ofs_t;

    typedef struct packed {
        logic c3;
        logic c2;
        logic c1;
    } carries_t;

    typedef struct packed {
        logic c2_d1;
        logic c3_d1;
        logic c3_d2;
    } carry_hist_t;

    function automatic ofs_t carry_term(input logic b);
        return ofs_t'({{(OFS_W-1){1'b0}}, b});
    endfunction

    function automatic logic [SEL_W-1:0] ofs_to_sel(input ofs_t o);
        logic [SEL_W-1:0] s;
        s = '0;
        for (int k = 0; k < SEL_W; k++) begin
            if (int'(o) == k + OFS_MIN) s[k] = 1'b1;
        end
        return s;
    endfunction
endpackage

// File: rtl/mash3_acc_stage.sv
`timescale 1ns/1ps
module mash3_acc_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] addend,
    output logic [W-1:0] next_res,
    output logic         carry
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    assign sum      = {1'b0, acc_q} + {1'b0, addend};
    assign carry    = sum[W];
    assign next_res = sum[W-1:0];

    always_ff @(posedge clk) begin
        if (rst)     acc_q <= '0;
        else if (en) acc_q <= next_res;
    end
endmodule

// File: rtl/mash3_recomb.sv
`timescale 1ns/1ps
module mash3_recomb
    import mash3_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  carries_t cy,
    output ofs_t     ofs_next
);
    carry_hist_t hist_q;

    // first-order difference of c2, second-order difference of c3
    always_comb begin
        ofs_next = carry_term(cy.c1)
                 + carry_term(cy.c2) - carry_term(hist_q.c2_d1)
                 + carry_term(cy.c3)
                 - (carry_term(hist_q.c3_d1) <<< 1)
                 + carry_term(hist_q.c3_d2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (en) begin
            hist_q.c2_d1 <= cy.c2;
            hist_q.c3_d2 <= hist_q.c3_d1;
            hist_q.c3_d1 <= cy.c3;
        end
    end
endmodule

// File: rtl/mash3_out_reg.sv
`timescale 1ns/1ps
module mash3_out_reg
    import mash3_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  ofs_t             ofs_next,
    output ofs_t             ofs_q,
    output logic [SEL_W-1:0] sel_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q <= '0;
            sel_q <= ofs_to_sel(ofs_t'(0));
        end else if (en) begin
            ofs_q <= ofs_next;
            sel_q <= ofs_to_sel(ofs_next);
        end
    end
endmodule

// File: rtl/mash3_modctl.sv
`timescale 1ns/1ps
module mash3_modctl
    import mash3_pkg::*;
#(
    parameter int FRAC_W = ACC_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [FRAC_W-1:0]        frac_word,
    output logic signed [OFS_W-1:0]  offset,
    output logic [SEL_W-1:0]         ratio_sel
);
    logic [FRAC_W-1:0] stage_in  [NUM_STAGES];
    logic [FRAC_W-1:0] stage_res [NUM_STAGES];
    logic [NUM_STAGES-1:0] stage_cy;
    carries_t cy;
    ofs_t     ofs_next;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign stage_in[i] = frac_word;
        end else begin : g_chain
            assign stage_in[i] = stage_res[i-1];
        end
        mash3_acc_stage #(.W(FRAC_W)) u_acc (
            .clk      (clk),
            .rst      (rst),
            .en       (en),
            .addend   (stage_in[i]),
            .next_res (stage_res[i]),
            .carry    (stage_cy[i])
        );
    end

    assign cy.c1 = stage_cy[0];
    assign cy.c2 = stage_cy[1];
    assign cy.c3 = stage_cy[2];

    mash3_recomb u_recomb (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .cy       (cy),
        .ofs_next (ofs_next)
    );

    mash3_out_reg u_out (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .ofs_next (ofs_next),
        .ofs_q    (offset),
        .sel_q    (ratio_sel)
    );

    logic unused_tail;
    assign unused_tail = ^stage_res[NUM_STAGES-1];
endmodule

// File: rtl/mash3_modctl_chk.sv
`timescale 1ns/1ps
module mash3_modctl_chk
    import mash3_pkg::*;
#(
    parameter int FRAC_W = ACC_W_DEF
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    en,
    input logic [FRAC_W-1:0]       frac_word,
    input logic signed [OFS_W-1:0] offset,
    input logic [SEL_W-1:0]        ratio_sel
);
    logic seen_edge = 1'b0;
    logic rst_prev  = 1'b0;

    always_ff @(posedge clk) begin
        if (seen_edge && rst_prev) begin
            a_r1_reset_clear: assert (offset == 0 && ratio_sel == 8'b0000_1000)
                else $error("R1 outputs not cleared by reset");
        end
        seen_edge <= 1'b1;
        rst_prev  <= rst;
    end

    a_r5_range: assert property (@(posedge clk) disable iff (rst)
        seen_edge |-> (int'(offset) >= OFS_MIN && int'(offset) <= OFS_MAX));

    a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
        seen_edge |-> $countones(ratio_sel) == 1);

    a_r6_index: assert property (@(posedge clk) disable iff (rst)
        seen_edge |-> ratio_sel[int'(offset) - OFS_MIN] == 1'b1);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(offset) && $stable(ratio_sel)));

    logic unused_fw;
    assign unused_fw = ^frac_word;
endmodule

bind mash3_modctl mash3_modctl_chk #(.FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/mash3_modctl_bench.sv
`timescale 1ns/1ps
module mash3_modctl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [15:0] frac_word = '0;
    logic signed [3:0] offset;
    logic [7:0]  ratio_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int m_a[3];
    int m_c2d, m_c3d1, m_c3d2;
    int exp_ofs;

    always #5 clk = ~clk;

    mash3_modctl u_mash3_modctl (
        .clk(clk), .rst(rst), .en(en), .frac_word(frac_word),
        .offset(offset), .ratio_sel(ratio_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit r, input bit e, input int f);
        int s, c1, c2, c3, r1, r2;
        if (r) begin
            foreach (m_a[k]) m_a[k] = 0;
            m_c2d = 0; m_c3d1 = 0; m_c3d2 = 0; exp_ofs = 0;
        end else if (e) begin
            s = m_a[0] + f;  c1 = s / 65536; r1 = s % 65536; m_a[0] = r1;
            s = m_a[1] + r1; c2 = s / 65536; r2 = s % 65536; m_a[1] = r2;
            s = m_a[2] + r2; c3 = s / 65536; m_a[2] = s % 65536;
            exp_ofs = c1 + c2 - m_c2d + c3 - 2 * m_c3d1 + m_c3d2;
            m_c2d = c2; m_c3d2 = m_c3d1; m_c3d1 = c3;
        end
    endtask

    // drive at negedge, model the edge, compare at the following negedge
    task automatic tick(input string req, input bit r, input bit e, input int f);
        rst = r; en = e; frac_word = f[15:0];
        @(posedge clk);
        model_step(r, e, f);
        @(negedge clk);
        check(req, int'(offset), exp_ofs);
        check("R6", int'(ratio_sel), 1 << (exp_ofs + 3));
    endtask

    initial begin
        #(1500000ns);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        longint acc_sum;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) tick("R1", 1, 0, 16'h1234);
        check("R1", int'(offset), 0);
        check("R1", int'(ratio_sel), 8);

        // R8: zero word from reset gives zero offset
        for (int i = 0; i < 20; i++) begin
            tick("R8", 0, 1, 0);
            check("R8", int'(offset), 0);
        end

        // R2: half-scale word, first carry on second edge
        for (int i = 0; i < 40; i++) tick("R2", 0, 1, 16'h8000);
        // R3/R4: assorted words exercise the cascade and recombination
        for (int i = 0; i < 60; i++) tick("R3", 0, 1, 16'h0001);
        for (int i = 0; i < 80; i++) tick("R4", 0, 1, 16'h4000);
        for (int i = 0; i < 200; i++) tick("R4", 0, 1, 16'h9C37);
        // R5: near full-scale word pushes the offset extremes
        for (int i = 0; i < 200; i++) begin
            tick("R5", 0, 1, 16'hFFFF);
            check("R5", int'(offset >= -3 && offset <= 4), 1);
        end

        // R7: enable low, changing word has no effect
        for (int i = 0; i < 12; i++) tick("R7", 0, 0, 16'h1111 * i);
        for (int i = 0; i < 30; i++) tick("R7", 0, 1, 16'h2D41);

        // R1: reset in mid-run clears history
        tick("R1", 1, 1, 16'h2D41);
        check("R1", int'(ratio_sel), 8);
        for (int i = 0; i < 30; i++) tick("R1", 0, 1, 16'h2D41);

        // R9: long-run mean over one full period
        tick("R9", 1, 0, 0);
        acc_sum = 0;
        for (int i = 0; i < 65536; i++) begin
            tick("R9", 0, 1, 16'h5A5A);
            acc_sum += longint'(offset);
        end
        check("R9", int'(acc_sum >= 16'h5A5A - 2 && acc_sum <= 16'h5A5A + 2), 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule